// File: doc/BRIEF.md
# Base-Offset Accumulator Load/Store Unit

This unit performs byte, word and double-word loads and stores against a byte-organized data memory. Each command carries a store/load flag, a size code and a signed 16-bit displacement. The unit sign-extends the displacement and adds it to an externally held 32-bit base register to form an absolute byte address. It then checks that address against a size-dependent legal window and runs a single access on a synchronous memory port with byte lanes.

The unit holds a pair of 32-bit accumulators. A load zero-extends the fetched data into the primary accumulator and moves the previous primary value into the secondary one. A store writes the low byte, the low word or all of the primary accumulator and leaves both accumulators as they were. Multi-byte quantities are big-endian: the most significant byte sits at the lowest address.

Data on the memory port is right-justified. For an access of n bytes at address A, lane k (bits 8k+7:8k) maps to byte address A+n-1-k. Only lanes 0 to n-1 are enabled.

Top module: `bofs_ldst_unit`

## Requirements
- R1: The access address driven on `mem_addr` equals `base_addr` plus `offset`, with `offset` read as a two's-complement value.
- R2: A byte load (`op_size`=00) sets accumulator 1 bits 7:0 to the addressed byte and bits 31:8 to zero.
- R3: A word load (`op_size`=01) sets accumulator 1 bits 15:8 to the byte at A and bits 7:0 to the byte at A+1, and clears bits 31:16.
- R4: A double-word load (`op_size`=10) sets accumulator 1 to the bytes at A..A+3, most significant byte first.
- R5: Every completed load writes the previous accumulator 1 value into accumulator 2.
- R6: A store (`op_store`=1) writes accumulator 1 bits 7:0, 15:0 or 31:0 (byte, word or double word) big-endian at A. `mem_be` is 0001, 0011 or 1111, and no other memory byte changes.
- R7: A store leaves both accumulators unchanged.
- R8: The absolute address is legal only when it is non-negative and at most 0xEFFF (byte), 0xEFFE (word) or 0xEFFC (double word). The sum is taken without wrap-around. An illegal command raises `err` together with `done`, issues no memory strobe, and changes neither accumulator.
- R9: Size code 11 is illegal and is handled like an out-of-range address (R8).
- R10: A command is accepted on a clock edge where `start` is high and `busy` is low.
  - `done` is a single-cycle pulse. It is high in the cycle after the second edge following acceptance for a load, and after the first edge for a store or error.
  - `busy` is high from acceptance until that `done`.
  - `start` while busy is ignored.
  - `mem_rd` and `mem_we` are high only in the cycle right after acceptance, and never together.
  - Read data is expected one cycle after `mem_rd`.
- R11: While `rst_n` is low, both accumulators are zero and `busy`, `done`, `err`, `mem_rd` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe |
| op_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 2 | 00 byte, 01 word, 10 double word, 11 illegal |
| offset | input | 16 | Signed displacement |
| base_addr | input | 32 | Base register value |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Address or size error, valid with done |
| accu1 | output | 32 | Primary accumulator |
| accu2 | output | 32 | Secondary accumulator |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Byte address of the access |
| mem_be | output | 4 | Lane enables |
| mem_wdata | output | 32 | Right-justified write data |
| mem_rdata | input | 32 | Right-justified read data, one cycle after mem_rd |

## Verification
The bench builds the unit with its default parameters: a 32-bit base, a 16-bit displacement, a 0xF000-byte legal window and zeroed idle write lanes. These defaults put every boundary of interest in direct reach of plain constants:
- all three size-dependent upper limits and the addresses one past them;
- the full negative displacement;
- a base near 2^32 whose sum would wrap in a 32-bit adder.

Read data on disabled lanes is filled with a non-zero pattern, so any failure to zero-extend a load shows up in the accumulators.

// File: rtl/bofs_pkg.sv
package bofs_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'b00,
      SZ_WORD  = 2'b01,
      SZ_DWORD = 2'b10,
      SZ_NONE  = 2'b11
   } acc_size_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } seq_state_e;

   // number of bytes an access of a given size moves; 0 marks an illegal code
   function automatic logic [2:0] size_bytes(acc_size_e s);
      case (s)
         SZ_BYTE:  return 3'd1;
         SZ_WORD:  return 3'd2;
         SZ_DWORD: return 3'd4;
         default:  return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/bofs_addr_gen.sv
module bofs_addr_gen
   import bofs_pkg::*;
#(
   parameter int unsigned     ADDR_W       = 32,
   parameter int unsigned     OFS_W        = 16,
   parameter longint unsigned WINDOW_BYTES = 64'hF000
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFS_W-1:0]  ofs,
   input  acc_size_e         size,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              legal
);
   localparam int unsigned SUM_W = ADDR_W + 1;

   logic [SUM_W-1:0] ofs_ext;
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] end_addr;
   logic [2:0]       nbytes;

   if (OFS_W >= ADDR_W) begin : g_bad_ofs
      $error("bofs_addr_gen: OFS_W must be narrower than ADDR_W");
   end

   // one extra bit keeps a negative result and a carry out of the base apart
   assign ofs_ext  = {{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs};
   assign sum      = {1'b0, base} + ofs_ext;
   assign eff_addr = sum[ADDR_W-1:0];
   assign nbytes   = size_bytes(size);
   assign end_addr = {1'b0, sum[ADDR_W-1:0]} + SUM_W'(nbytes);

   assign legal = !sum[SUM_W-1] && (nbytes != 3'd0)
                  && (end_addr <= SUM_W'(WINDOW_BYTES));

endmodule

// File: rtl/bofs_lane_pack.sv
module bofs_lane_pack
   import bofs_pkg::*;
#(
   parameter int unsigned DATA_W          = 32,
   parameter bit          ZERO_IDLE_LANES = 1'b1
) (
   input  acc_size_e           size,
   input  logic [DATA_W-1:0]   accu,
   input  logic [DATA_W-1:0]   rdata,
   output logic [DATA_W/8-1:0] be,
   output logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   ldata
);
   localparam int unsigned LANES = DATA_W / 8;

   logic [2:0] nbytes;
   assign nbytes = size_bytes(size);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign be[k]            = (k < int'(nbytes));
      assign ldata[k*8 +: 8]  = be[k] ? rdata[k*8 +: 8] : 8'h00;
      if (ZERO_IDLE_LANES) begin : g_zero
         assign wdata[k*8 +: 8] = be[k] ? accu[k*8 +: 8] : 8'h00;
      end else begin : g_pass
         assign wdata[k*8 +: 8] = accu[k*8 +: 8];
      end
   end

endmodule

// File: rtl/bofs_ctrl.sv
module bofs_ctrl
   import bofs_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_store,
   input  acc_size_e         size,
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic              legal,
   output logic [ADDR_W-1:0] addr_q,
   output acc_size_e         size_q,
   output logic              mem_rd,
   output logic              mem_we,
   output logic              ld_en,
   output logic              busy,
   output logic              done,
   output logic              err
);
   seq_state_e state;
   logic       store_q;
   logic       bad_q;
   logic       done_q;
   logic       err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         addr_q  <= '0;
         size_q  <= SZ_BYTE;
         store_q <= 1'b0;
         bad_q   <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  addr_q  <= eff_addr;
                  size_q  <= size;
                  store_q <= is_store;
                  bad_q   <= !legal;
                  state   <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (bad_q || store_q) begin
                  done_q <= 1'b1;
                  err_q  <= bad_q;
                  state  <= ST_IDLE;
               end else begin
                  state  <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               done_q <= 1'b1;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd = (state == ST_ISSUE) && !store_q && !bad_q;
   assign mem_we = (state == ST_ISSUE) &&  store_q && !bad_q;
   assign ld_en  = (state == ST_WAIT);
   assign busy   = (state != ST_IDLE);
   assign done   = done_q;
   assign err    = err_q;

   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_we));
   p_strobe_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_we) |-> $past(start) && !$past(busy));
   p_err_pairs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

endmodule

// File: rtl/bofs_accu.sv
module bofs_accu #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [DATA_W-1:0] ldata,
   output logic [DATA_W-1:0] acc1,
   output logic [DATA_W-1:0] acc2
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc1 <= '0;
         acc2 <= '0;
      end else if (ld_en) begin
         acc2 <= acc1;
         acc1 <= ldata;
      end
   end

   p_load_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> acc2 == $past(acc1));
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> $stable(acc1) && $stable(acc2));

endmodule

// File: rtl/bofs_ldst_unit.sv
module bofs_ldst_unit
   import bofs_pkg::*;
#(
   parameter int unsigned     ADDR_W          = 32,
   parameter int unsigned     OFS_W           = 16,
   parameter int unsigned     DATA_W          = 32,
   parameter longint unsigned WINDOW_BYTES    = 64'hF000,
   parameter bit              ZERO_IDLE_LANES = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                op_store,
   input  logic [1:0]          op_size,
   input  logic [OFS_W-1:0]    offset,
   input  logic [ADDR_W-1:0]   base_addr,
   output logic                busy,
   output logic                done,
   output logic                err,
   output logic [DATA_W-1:0]   accu1,
   output logic [DATA_W-1:0]   accu2,
   output logic                mem_rd,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata
);
   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned SUM_W = ADDR_W + 1;

   if (DATA_W != 32) begin : g_bad_data
      $error("bofs_ldst_unit: accumulator width must be 32");
   end
   if (WINDOW_BYTES == 0 || WINDOW_BYTES > (64'd1 << ADDR_W)) begin : g_bad_win
      $error("bofs_ldst_unit: WINDOW_BYTES outside the address space");
   end

   acc_size_e           size_in;
   acc_size_e           size_q;
   logic [ADDR_W-1:0]   eff_addr;
   logic                legal;
   logic                ld_en;
   logic                rd_s;
   logic                we_s;
   logic [LANES-1:0]    be_raw;
   logic [DATA_W-1:0]   ldata;

   assign size_in = acc_size_e'(op_size);

   bofs_addr_gen #(
      .ADDR_W(ADDR_W), .OFS_W(OFS_W), .WINDOW_BYTES(WINDOW_BYTES)
   ) u_addr (
      .base(base_addr), .ofs(offset), .size(size_in),
      .eff_addr(eff_addr), .legal(legal)
   );

   bofs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .is_store(op_store),
      .size(size_in), .eff_addr(eff_addr), .legal(legal),
      .addr_q(mem_addr), .size_q(size_q), .mem_rd(rd_s), .mem_we(we_s),
      .ld_en(ld_en), .busy(busy), .done(done), .err(err)
   );

   bofs_lane_pack #(.DATA_W(DATA_W), .ZERO_IDLE_LANES(ZERO_IDLE_LANES)) u_pack (
      .size(size_q), .accu(accu1), .rdata(mem_rdata),
      .be(be_raw), .wdata(mem_wdata), .ldata(ldata)
   );

   bofs_accu #(.DATA_W(DATA_W)) u_accu (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ldata(ldata),
      .acc1(accu1), .acc2(accu2)
   );

   assign mem_rd = rd_s;
   assign mem_we = we_s;
   assign mem_be = be_raw & {LANES{rd_s | we_s}};

   p_addr_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_we) |->
         ({1'b0, mem_addr} + SUM_W'($countones(mem_be))) <= SUM_W'(WINDOW_BYTES));
   p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_we) |->
         (mem_be == 4'b0001 || mem_be == 4'b0011 || mem_be == 4'b1111));
   p_store_keeps_accu_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> $stable(accu1) && $stable(accu2));
   p_err_keeps_accu_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> $stable(accu1) && $stable(accu2));
   p_byte_zero_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && size_q == SZ_BYTE) |=> accu1[DATA_W-1:8] == '0);

endmodule

// File: tb/bofs_ldst_unit_bench.sv
module bofs_ldst_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        op_store = 1'b0;
   logic [1:0]  op_size = 2'b00;
   logic [15:0] offset = '0;
   logic [31:0] base_addr = '0;
   logic        busy, done, err, mem_rd, mem_we;
   logic [31:0] accu1, accu2, mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic [31:0] mem_rdata = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   bofs_ldst_unit u_bofs_ldst_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .op_store(op_store),
      .op_size(op_size), .offset(offset), .base_addr(base_addr),
      .busy(busy), .done(done), .err(err), .accu1(accu1), .accu2(accu2),
      .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   task automatic chk(input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // ---------------- memory seen by the design ----------------
   logic [7:0]  dut_mem [0:65535];
   logic [7:0]  ref_mem [0:65535];
   logic        l_rd = 0, l_we = 0;
   logic [31:0] l_addr = 0, l_wd = 0;
   logic [3:0]  l_be = 0;

   always @(negedge clk) begin
      l_rd = mem_rd; l_we = mem_we; l_addr = mem_addr; l_be = mem_be; l_wd = mem_wdata;
   end

   always @(posedge clk) begin
      int n;
      logic [31:0] tmp;
      n = $countones(l_be);
      if (l_we)
         for (int k = 0; k < 4; k++)
            if (l_be[k]) dut_mem[16'(l_addr + 32'(n - 1 - k))] = l_wd[k*8 +: 8];
      if (l_rd) begin
         tmp = 32'hA5C3_5A3C;
         for (int k = 0; k < 4; k++)
            if (l_be[k]) tmp[k*8 +: 8] = dut_mem[16'(l_addr + 32'(n - 1 - k))];
         mem_rdata <= tmp;
      end
   end

   // ---------------- behavioural reference ----------------
   int          pend = 0;
   bit          e_done = 0, e_err = 0, e_issue = 0;
   logic [31:0] e_a1 = 0, e_a2 = 0;
   bit          m_store = 0, m_bad = 0;
   int          m_n = 0;
   longint      m_addr = 0;
   logic [31:0] m_ldata = 0;
   string       m_tag = "R11";

   always @(posedge clk) begin
      bit acc;
      if (!rst_n) begin
         pend = 0; e_done = 0; e_err = 0; e_issue = 0; e_a1 = 0; e_a2 = 0;
      end else begin
         acc = start && (pend == 0);
         if (pend > 0) begin
            pend--;
            e_done = (pend == 0);
            e_err  = e_done && m_bad;
            if (e_done && !m_bad && !m_store) begin
               e_a2 = e_a1;
               e_a1 = m_ldata;
            end
            if (e_done && !m_bad && m_store)
               for (int i = 0; i < m_n; i++)
                  ref_mem[16'(m_addr + i)] = 8'(e_a1 >> (8 * (m_n - 1 - i)));
         end else begin
            e_done = 0; e_err = 0;
         end
         e_issue = acc;
         if (acc) begin
            m_store = op_store;
            m_n = (op_size == 2'b00) ? 1 : (op_size == 2'b01) ? 2 : (op_size == 2'b10) ? 4 : 0;
            m_addr = longint'(base_addr) + longint'($signed(offset));
            m_bad = (m_n == 0) || (m_addr < 0) || (m_addr + m_n > 64'hF000);
            m_ldata = 0;
            if (!m_bad && !m_store)
               for (int i = 0; i < m_n; i++)
                  m_ldata = (m_ldata << 8) | 32'(ref_mem[16'(m_addr + i)]);
            if (m_n == 0)          m_tag = "R9";
            else if (m_bad)        m_tag = "R8";
            else if (m_store)      m_tag = "R7";
            else if (m_n == 1)     m_tag = "R2";
            else if (m_n == 2)     m_tag = "R3";
            else                   m_tag = "R4";
            pend = (m_bad || m_store) ? 1 : 2;
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R10", "busy", busy, pend > 0);
         chk("R10", "done", done, e_done);
         chk(m_n == 0 ? "R9" : "R8", "err", err, e_err);
         chk(m_tag, "accu1", accu1, e_a1);
         chk((m_tag == "R2" || m_tag == "R3" || m_tag == "R4") ? "R5" : m_tag,
             "accu2", accu2, e_a2);
         chk(m_bad ? m_tag : "R10", "mem_rd", mem_rd, e_issue && !m_store && !m_bad);
         chk(m_bad ? m_tag : "R10", "mem_we", mem_we, e_issue && m_store && !m_bad);
         if (e_issue && !m_bad) begin
            chk("R1", "mem_addr", mem_addr, m_addr);
            chk("R6", "mem_be", mem_be, (1 << m_n) - 1);
            if (m_store)
               chk("R6", "mem_wdata", mem_wdata & ((64'd1 << (8 * m_n)) - 1),
                   e_a1 & ((64'd1 << (8 * m_n)) - 1));
         end
      end
   end

   task automatic run_op(input logic st, input logic [1:0] sz,
                         input logic [15:0] ofs, input logic [31:0] base,
                         input int hold = 1);
      @(posedge clk); #2;
      start = 1; op_store = st; op_size = sz; offset = ofs; base_addr = base;
      repeat (hold) @(posedge clk);
      #2 start = 0;
      repeat (4) @(posedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      for (int a = 0; a < 65536; a++) begin
         dut_mem[a] = 8'((a * 37 + 11) ^ (a >> 8));
         ref_mem[a] = dut_mem[a];
      end
      repeat (3) @(posedge clk);
      #2;
      // R11: reset state
      chk("R11", "accu1 in reset", accu1, 0);
      chk("R11", "accu2 in reset", accu2, 0);
      chk("R11", "busy/done/err in reset", {busy, done, err}, 0);
      chk("R11", "strobes in reset", {mem_rd, mem_we}, 0);
      rst_n = 1;

      // R2 R3 R4 R5 R1: loads with positive, negative and extreme displacements
      run_op(0, 2'b00, 16'd5,    32'h0000_1000);
      run_op(0, 2'b01, 16'hFFFE, 32'h0000_1000);
      run_op(0, 2'b10, 16'h7FFF, 32'h0000_1000);
      run_op(0, 2'b10, 16'h8000, 32'h0000_9000);
      run_op(0, 2'b01, 16'd3,    32'h0000_2001);
      // R6 R7: stores of each size, then read back
      run_op(1, 2'b00, 16'd0,    32'h0000_3000);
      run_op(1, 2'b01, 16'd1,    32'h0000_3010);
      run_op(1, 2'b10, 16'hFFFF, 32'h0000_3021);
      run_op(0, 2'b10, 16'd0,    32'h0000_3000);
      run_op(0, 2'b10, 16'd0,    32'h0000_3010);
      run_op(0, 2'b10, 16'd0,    32'h0000_3020);
      // R8: size-dependent upper limits
      run_op(0, 2'b00, 16'd0,    32'h0000_EFFF);
      run_op(0, 2'b00, 16'd1,    32'h0000_EFFF);
      run_op(0, 2'b01, 16'd0,    32'h0000_EFFE);
      run_op(1, 2'b01, 16'd1,    32'h0000_EFFE);
      run_op(1, 2'b10, 16'd0,    32'h0000_EFFC);
      run_op(0, 2'b10, 16'd1,    32'h0000_EFFC);
      run_op(1, 2'b00, 16'hFFEF, 32'h0000_0010);
      run_op(0, 2'b00, 16'h0020, 32'hFFFF_FFF0);
      run_op(0, 2'b00, 16'd0,    32'h0000_0000);
      // R9: illegal size code, load and store
      run_op(0, 2'b11, 16'd0,    32'h0000_0100);
      run_op(1, 2'b11, 16'd0,    32'h0000_0100);
      // R10: start held while busy must not start a second command
      run_op(0, 2'b01, 16'd8,    32'h0000_4000, 2);
      run_op(1, 2'b00, 16'd9,    32'h0000_4000, 2);
      run_op(0, 2'b00, 16'd9,    32'h0000_4000);

      begin
         int mism = 0;
         for (int a = 0; a < 65536; a++)
            if (dut_mem[a] !== ref_mem[a]) mism++;
         chk("R6", "bytes differing in memory image", mism, 0);
      end
      finished = 1;
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL R10 watchdog: actual hung expected completion");
         finish_run();
      end
   end

endmodule